// File: doc/BRIEF.md
# Extended-Precision Partial Remainder Unit

This unit takes two extended-precision operands, a dividend and a divisor, and returns the partial remainder of the dividend modulo the divisor. Each operand has a sign bit, a 16-bit biased exponent (bias 16383, all-ones meaning infinity or NaN) and a 64-bit significand whose top bit is an explicit integer bit. Inputs are taken to be normalized or zero.

The quotient is formed one bit per clock by restoring shift-and-subtract. A single call never runs more than 64 quotient steps. When the exponent gap is too large for that, the unit performs a bounded partial reduction and raises an incomplete flag, so the caller issues the operation again. A mode input selects a truncated quotient or a quotient rounded to the nearest integer. In the rounded case the remainder may change sign, and ties go to the even quotient. The three low quotient bits come back on fixed positions of a 4-bit condition code. Zero, infinity and NaN operands are classified and handled before any arithmetic is done.

Top module: `fprem_unit`

## Requirements
- R1: Let D = dividend exponent − divisor exponent. For finite nonzero operands with D ≤ −2, the result equals the dividend and condCode is 0.
- R2: For finite nonzero operands with −1 ≤ D ≤ 63 and truncation mode, the quotient q is |a/b| truncated. The result is |a| − q·|b| with the dividend's sign, normalized so that resSig[63] = 1. A zero remainder is returned as exponent 0 and significand 0, carrying the dividend's sign.
- R3: On a complete reduction, condCode bit 0 = q[2], bit 3 = q[1], bit 1 = q[0] and bit 2 = 0.
- R4: In round-to-nearest mode (roundNearest = 1) with −1 ≤ D ≤ 63, let x = |b| − remainder. If x < remainder, or x equals the remainder and q is odd, then the result magnitude becomes x, its sign is inverted and q is incremented before the flags of R3 are taken.
- R5: For D ≥ 64 the unit uses N = (D mod 32) + 32 quotient steps. It returns |a·2^(N−D)| mod |b| scaled by 2^(D−N), with the dividend's sign and no rounding correction, and condCode = 4'b0100 (bit 2 marks the result as incomplete).
- R6: If a partial reduction leaves a zero remainder, the result is a zero with the dividend's sign and condCode = 4'b0100.
- R7: A zero divisor, or an infinite dividend with a non-NaN divisor, sets invalidOp. The result is then sign 1, exponent 16'hFFFF, significand 64'hC000_0000_0000_0000, with condCode 0.
- R8: A zero dividend with a non-NaN nonzero divisor, or a finite dividend with an infinite divisor, returns the dividend unchanged with condCode 0 and invalidOp 0.
- R9: When the dividend is a NaN it is returned, otherwise a NaN divisor is returned. In both cases significand bit 62 is forced to 1, condCode is 0 and invalidOp is 0.
- R10: done is a one-cycle pulse that comes at most 66 cycles after the unit leaves idle. A start raised while an operation is in progress is ignored and produces no result. The result outputs change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one operation when the unit is idle |
| roundNearest | input | 1 | 1 selects a round-to-nearest quotient, 0 a truncated quotient |
| aSign | input | 1 | Dividend sign |
| aExp | input | 16 | Dividend biased exponent |
| aSig | input | 64 | Dividend significand |
| bSign | input | 1 | Divisor sign |
| bExp | input | 16 | Divisor biased exponent |
| bSig | input | 64 | Divisor significand |
| done | output | 1 | One-cycle pulse marking the result as valid |
| resSign | output | 1 | Result sign |
| resExp | output | 16 | Result biased exponent |
| resSig | output | 64 | Result significand |
| condCode | output | 4 | {q[1], incomplete, q[0], q[2]} |
| invalidOp | output | 1 | Invalid-operation flag |

## Verification
Some properties are checked on every cycle. done never lasts two cycles. The result outputs hold their value outside the done cycle. A busy period stays within its 66-cycle bound. Any finite nonzero result is normalized. An invalid result carries the all-ones exponent with clear flags, and an incomplete result is never invalid.

The remaining behaviour depends on the numbers and is shown only by the bench's scenarios: the remainder values, the placement of the quotient bits, ties to the even quotient in round-to-nearest mode, the choice of N and the exponent of a partial reduction, signed zeros, NaN priority, and the rejection of a start issued while busy.

// File: rtl/fprem_pkg.sv
package fprem_pkg;
  parameter int EXP_W = 16;
  parameter int SIG_W = 64;
  localparam int CNT_W = $clog2(SIG_W);

  typedef enum logic [2:0] {
    KD_PASS, KD_NANA, KD_NANB, KD_INVAL, KD_HALF, KD_FULL, KD_PART
  } kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic init;
    logic step;
    logic finish;
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic fast;
    logic lastStep;
  } status_t;
endpackage

// File: rtl/fprem_dp.sv
module fprem_dp
  import fprem_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       stb,
  output status_t       sts,
  input  logic          roundNearest,
  input  logic          aSign,
  input  logic [EW-1:0] aExp,
  input  logic [SW-1:0] aSig,
  input  logic          bSign,
  input  logic [EW-1:0] bExp,
  input  logic [SW-1:0] bSig,
  output logic          resSign,
  output logic [EW-1:0] resExp,
  output logic [SW-1:0] resSig,
  output logic [3:0]    condCode,
  output logic          invalidOp
);
  localparam int CW = $clog2(SW);
  localparam int DW = EW + 2;
  localparam logic [SW-1:0] QUIET = {2'b01, {(SW-2){1'b0}}};
  localparam logic [SW-1:0] INDEF = {2'b11, {(SW-2){1'b0}}};

  logic          aS, bS, rndR;
  logic [EW-1:0] aE, bE, baseExp;
  logic [SW-1:0] aM, bM;
  logic [SW:0]   rem, dvs;
  logic [2:0]    quo;
  logic [CW-1:0] cnt;
  kind_e         kind, kindNext;

  // operand classes from latched operands
  logic aNan, aInf, aZero, bNan, bInf, bZero;
  assign aNan  = (aE == '1) && (|aM[SW-2:0]);
  assign aInf  = (aE == '1) && !(|aM[SW-2:0]);
  assign aZero = (aE == '0) && (aM == '0);
  assign bNan  = (bE == '1) && (|bM[SW-2:0]);
  assign bInf  = (bE == '1) && !(|bM[SW-2:0]);
  assign bZero = (bE == '0) && (bM == '0);

  logic signed [DW-1:0] expDiff;
  logic [CW-1:0]        partN;
  assign expDiff = $signed({2'b00, aE}) - $signed({2'b00, bE});
  assign partN   = {1'b1, expDiff[CW-2:0]};

  always_comb begin
    if (aNan)                     kindNext = KD_NANA;
    else if (bNan)                kindNext = KD_NANB;
    else if (bZero || aInf)       kindNext = KD_INVAL;
    else if (aZero || bInf)       kindNext = KD_PASS;
    else if (expDiff <= -2)       kindNext = KD_PASS;
    else if (expDiff == -1)       kindNext = KD_HALF;
    else if (expDiff < DW'(SW))   kindNext = KD_FULL;
    else                          kindNext = KD_PART;
  end

  assign sts.fast     = (kindNext != KD_FULL) && (kindNext != KD_PART);
  assign sts.lastStep = (cnt == '0);

  // one restoring step
  logic          geDvs;
  logic [SW:0]   stepRem;
  assign geDvs   = rem >= dvs;
  assign stepRem = geDvs ? rem - dvs : rem;

  // finishing: nearest correction, normalization
  logic [SW:0]   alt;
  logic          doRound;
  logic [SW-1:0] fin, normSig;
  logic [2:0]    quoF;
  logic [CW:0]   lz;
  logic [EW-1:0] normExp;

  function automatic logic [CW:0] lead0(input logic [SW-1:0] v);
    lead0 = (CW+1)'(SW);
    for (int i = 0; i < SW; i++) if (v[i]) lead0 = (CW+1)'(SW - 1 - i);
  endfunction

  assign alt     = dvs - rem;
  assign doRound = rndR && (kind == KD_HALF || kind == KD_FULL) &&
                   ((alt < rem) || ((alt == rem) && quo[0]));
  assign fin     = doRound ? alt[SW-1:0] : rem[SW-1:0];
  assign quoF    = quo + {2'b00, doRound};
  assign lz      = lead0(fin);
  assign normSig = fin << lz;
  assign normExp = baseExp - EW'(lz);

  always_ff @(posedge clk) begin
    if (rst) begin
      {aS, aE, aM, bS, bE, bM, rndR} <= '0;
      {rem, dvs, quo, cnt, baseExp}  <= '0;
      kind      <= KD_PASS;
      resSign   <= 1'b0;
      resExp    <= '0;
      resSig    <= '0;
      condCode  <= '0;
      invalidOp <= 1'b0;
    end else begin
      if (stb.load) begin
        aS <= aSign; aE <= aExp; aM <= aSig;
        bS <= bSign; bE <= bExp; bM <= bSig;
        rndR <= roundNearest;
      end
      if (stb.init) begin
        kind <= kindNext;
        rem  <= {1'b0, aM};
        dvs  <= (kindNext == KD_HALF) ? {bM, 1'b0} : {1'b0, bM};
        quo  <= '0;
        cnt  <= (kindNext == KD_FULL) ? expDiff[CW-1:0] : partN;
        case (kindNext)
          KD_FULL: baseExp <= bE;
          KD_PART: baseExp <= aE - EW'(partN);
          default: baseExp <= aE;
        endcase
      end
      if (stb.step) begin
        quo <= {quo[1:0], geDvs};
        rem <= sts.lastStep ? stepRem : {stepRem[SW-1:0], 1'b0};
        cnt <= cnt - 1'b1;
      end
      if (stb.finish) begin
        condCode  <= '0;
        invalidOp <= 1'b0;
        case (kind)
          KD_PASS: {resSign, resExp, resSig} <= {aS, aE, aM};
          KD_NANA: {resSign, resExp, resSig} <= {aS, aE, aM | QUIET};
          KD_NANB: {resSign, resExp, resSig} <= {bS, bE, bM | QUIET};
          KD_INVAL: begin
            {resSign, resExp, resSig} <= {1'b1, {EW{1'b1}}, INDEF};
            invalidOp <= 1'b1;
          end
          default: begin
            resSign <= aS ^ doRound;
            resExp  <= (fin == '0) ? '0 : normExp;
            resSig  <= normSig;
            condCode <= (kind == KD_PART) ? 4'b0100
                                          : {quoF[1], 1'b0, quoF[0], quoF[2]};
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fprem_ctrl.sv
module fprem_ctrl
  import fprem_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  status_t sts,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_LOOP, ST_FIN} state_e;
  state_e st, nxt;

  always_comb begin
    stb = '0;
    nxt = st;
    case (st)
      ST_IDLE: if (start) begin stb.load = 1'b1; nxt = ST_PREP; end
      ST_PREP: begin stb.init = 1'b1; nxt = sts.fast ? ST_FIN : ST_LOOP; end
      ST_LOOP: begin stb.step = 1'b1; if (sts.lastStep) nxt = ST_FIN; end
      default: begin stb.finish = 1'b1; nxt = ST_IDLE; end
    endcase
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      done <= stb.finish;
    end
  end
endmodule

// File: rtl/fprem_unit.sv
module fprem_unit
  import fprem_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          roundNearest,
  input  logic          aSign,
  input  logic [EW-1:0] aExp,
  input  logic [SW-1:0] aSig,
  input  logic          bSign,
  input  logic [EW-1:0] bExp,
  input  logic [SW-1:0] bSig,
  output logic          done,
  output logic          resSign,
  output logic [EW-1:0] resExp,
  output logic [SW-1:0] resSig,
  output logic [3:0]    condCode,
  output logic          invalidOp
);
  strobe_t stb;
  status_t sts;
  logic    busy;

  fprem_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .sts(sts),
    .stb(stb), .busy(busy), .done(done)
  );

  fprem_dp #(.EW(EW), .SW(SW)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .sts(sts),
    .roundNearest(roundNearest),
    .aSign(aSign), .aExp(aExp), .aSig(aSig),
    .bSign(bSign), .bExp(bExp), .bSig(bSig),
    .resSign(resSign), .resExp(resExp), .resSig(resSig),
    .condCode(condCode), .invalidOp(invalidOp)
  );
endmodule

// File: rtl/fprem_chk.sv
module fprem_chk #(
  parameter int EW = 16,
  parameter int SW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          busy,
  input logic          invalidOp,
  input logic [3:0]    condCode,
  input logic [EW-1:0] resExp,
  input logic [SW-1:0] resSig
);
  logic [7:0] busyCnt;
  always_ff @(posedge clk) begin
    if (rst) busyCnt <= '0;
    else     busyCnt <= busy ? busyCnt + 1'b1 : '0;
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(resSig) && $stable(resExp) && $stable(condCode)));

  assert_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    busyCnt <= 8'(SW + 2));

  assert_normalized_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !invalidOp && resExp != '0 && resExp != '1) |-> resSig[SW-1]);

  assert_invalid_form_R7: assert property (@(posedge clk) disable iff (rst)
    (done && invalidOp) |-> (resExp == '1 && condCode == 4'b0000));

  assert_incomplete_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (done && condCode[2]) |-> !invalidOp);
endmodule

bind fprem_unit fprem_chk #(.EW(EW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .busy(busy), .invalidOp(invalidOp),
  .condCode(condCode), .resExp(resExp), .resSig(resSig)
);

// File: tb/fprem_unit_bench.sv
module fprem_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BIAS = 16'd16383;
  localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, roundNearest = 1'b0;
  logic        aSign = 1'b0, bSign = 1'b0;
  logic [15:0] aExp = '0, bExp = '0;
  logic [63:0] aSig = '0, bSig = '0;
  logic        done, resSign, invalidOp;
  logic [15:0] resExp;
  logic [63:0] resSig;
  logic [3:0]  condCode;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fprem_unit u_fprem_unit (
    .clk(clk), .rst(rst), .start(start), .roundNearest(roundNearest),
    .aSign(aSign), .aExp(aExp), .aSig(aSig),
    .bSign(bSign), .bExp(bExp), .bSig(bSig),
    .done(done), .resSign(resSign), .resExp(resExp), .resSig(resSig),
    .condCode(condCode), .invalidOp(invalidOp)
  );

  typedef struct {
    logic        s;
    logic [15:0] e;
    logic [63:0] m;
    logic [3:0]  cc;
    logic        inv;
    string       req;
  } exp_t;

  exp_t sb[$];

  function automatic exp_t model(input logic as_, input logic [15:0] ae, input logic [63:0] am,
                                 input logic bs, input logic [15:0] be, input logic [63:0] bm,
                                 input logic near, input string req);
    exp_t r;
    int d, n, base;
    logic [191:0] num, qt, rm;
    logic [64:0] dv, x, rr;
    logic flip;
    bit aNan, aInf, aZero, bNan, bInf, bZero;
    aNan  = ae == 16'hFFFF && am[62:0] != 0;
    aInf  = ae == 16'hFFFF && am[62:0] == 0;
    aZero = ae == 0 && am == 0;
    bNan  = be == 16'hFFFF && bm[62:0] != 0;
    bInf  = be == 16'hFFFF && bm[62:0] == 0;
    bZero = be == 0 && bm == 0;
    r.req = req; r.cc = 4'b0; r.inv = 1'b0;
    d = int'(ae) - int'(be);
    if (aNan) begin r.s = as_; r.e = ae; r.m = am | 64'h4000_0000_0000_0000; end
    else if (bNan) begin r.s = bs; r.e = be; r.m = bm | 64'h4000_0000_0000_0000; end
    else if (bZero || aInf) begin
      r.s = 1'b1; r.e = 16'hFFFF; r.m = 64'hC000_0000_0000_0000; r.inv = 1'b1;
    end
    else if (aZero || bInf || d <= -2) begin r.s = as_; r.e = ae; r.m = am; end
    else begin
      if (d == -1) begin
        rr = {1'b0, am}; dv = {bm, 1'b0}; qt = '0; base = int'(ae);
      end else begin
        n = (d < 64) ? d : (d % 32) + 32;
        num = {128'd0, am} << n;
        qt = num / {128'd0, bm};
        rm = num % {128'd0, bm};
        rr = rm[64:0]; dv = {1'b0, bm};
        base = (d < 64) ? int'(be) : int'(ae) - n;
      end
      flip = 1'b0;
      if (near && d < 64) begin
        x = dv - rr;
        if (x < rr || (x == rr && qt[0])) begin rr = x; qt = qt + 1; flip = 1'b1; end
      end
      r.s = as_ ^ flip;
      if (rr == 0) begin r.e = '0; r.m = '0; end
      else begin
        while (!rr[63]) begin rr = rr << 1; base--; end
        r.e = 16'(base); r.m = rr[63:0];
      end
      r.cc = (d >= 64) ? 4'b0100 : {qt[1], 1'b0, qt[0], qt[2]};
    end
    return r;
  endfunction

  // driver: push the expected item, pulse start, optionally poke start while busy
  task automatic issue(input logic as_, input logic [15:0] ae, input logic [63:0] am,
                       input logic bs, input logic [15:0] be, input logic [63:0] bm,
                       input logic near, input string req, input bit noise = 1'b0);
    sb.push_back(model(as_, ae, am, bs, be, bm, near, req));
    @(negedge clk);
    aSign = as_; aExp = ae; aSig = am; bSign = bs; bExp = be; bSig = bm;
    roundNearest = near; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (noise) begin
      repeat (3) @(negedge clk);
      aExp = ae + 16'd1; aSig = ~am | ONE; roundNearest = ~near; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  // monitor: compare each result against the scoreboard
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prevDone) begin
        checks++; errors++;
        $display("FAIL R10 done high two cycles: actual 1 expected 0");
      end
      if (done) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result: actual done=1 expected done=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (resSign !== e.s || resExp !== e.e || resSig !== e.m ||
              condCode !== e.cc || invalidOp !== e.inv) begin
            errors++;
            $display("FAIL %s actual s=%0b e=%h m=%h cc=%b inv=%0b expected s=%0b e=%h m=%h cc=%b inv=%0b",
                     e.req, resSign, resExp, resSig, condCode, invalidOp,
                     e.s, e.e, e.m, e.cc, e.inv);
          end
        end
      end
    end
    prevDone = done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || resSig !== '0 || condCode !== '0 || invalidOp !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset state: actual done=%0b sig=%h cc=%b expected 0", done, resSig, condCode);
    end

    // R2 / R3: 7 rem 2 truncated -> 1, q=3
    issue(0, BIAS+2, 64'hE000_0000_0000_0000, 0, BIAS+1, ONE, 0, "R2_R3 7rem2");
    // R4: tie with odd quotient -> -1, q=4
    issue(0, BIAS+2, 64'hE000_0000_0000_0000, 0, BIAS+1, ONE, 1, "R4 tie odd");
    // R4: tie with even quotient -> stays +1
    issue(0, BIAS+2, 64'hA000_0000_0000_0000, 0, BIAS+1, ONE, 1, "R4 tie even");
    // R4: remainder above half
    issue(0, BIAS+2, 64'hF000_0000_0000_0000, 0, BIAS+1, ONE, 1, "R4 above half");
    // R2: exact zero remainder, both signs
    issue(0, BIAS+3, ONE, 0, BIAS+1, ONE, 0, "R2 zero pos");
    issue(1, BIAS+3, ONE, 1, BIAS+1, ONE, 0, "R2 zero neg");
    // R2: negative divisor does not change result sign
    issue(0, BIAS+5, 64'hD123_4567_89AB_CDEF, 1, BIAS+1, 64'hB000_0000_0000_0001, 0, "R2 neg divisor");
    // D = -1 in both modes
    issue(0, BIAS, 64'hC000_0000_0000_0000, 0, BIAS+1, ONE, 0, "R2 D=-1 trunc");
    issue(0, BIAS, 64'hC000_0000_0000_0000, 0, BIAS+1, ONE, 1, "R4 D=-1 near");
    // R1: small dividend
    issue(1, BIAS-2, 64'hC000_0000_0000_0000, 0, BIAS+1, 64'hC000_0000_0000_0000, 1, "R1 D=-3");
    // D = 63 boundary
    issue(0, BIAS+63, 64'hFFFF_FFFF_FFFF_FFFF, 0, BIAS, 64'h8000_0000_0000_0003, 0, "R2_R3 D=63");
    // R5: partial reductions
    issue(0, BIAS+64, 64'hFFFF_FFFF_FFFF_FFFF, 0, BIAS, 64'h8000_0000_0000_0003, 1, "R5 D=64");
    issue(1, BIAS+100, 64'hABCD_EF01_2345_6789, 0, BIAS, 64'hC000_0000_0000_0007, 0, "R5 D=100");
    // R6: partial with zero remainder
    issue(1, BIAS+100, ONE, 0, BIAS, ONE, 0, "R6 partial zero");
    // R7: invalid cases
    issue(0, BIAS, ONE, 0, 16'h0, 64'h0, 0, "R7 zero divisor");
    issue(0, 16'h0, 64'h0, 0, 16'h0, 64'h0, 0, "R7 zero by zero");
    issue(1, 16'hFFFF, ONE, 0, BIAS, ONE, 0, "R7 inf dividend");
    // R8: pass-through cases
    issue(1, 16'h0, 64'h0, 0, BIAS, ONE, 1, "R8 zero dividend");
    issue(0, BIAS+9, 64'h9000_0000_0000_0000, 1, 16'hFFFF, ONE, 0, "R8 inf divisor");
    // R9: NaN propagation
    issue(0, 16'hFFFF, 64'h8000_0000_0000_0001, 0, BIAS, ONE, 0, "R9 nan dividend");
    issue(0, BIAS, ONE, 1, 16'hFFFF, 64'h8000_0000_0000_0002, 0, "R9 nan divisor");
    issue(1, 16'hFFFF, 64'hC000_0000_0000_0005, 0, 16'hFFFF, 64'h8000_0000_0000_0002, 0, "R9 both nan");
    // R10: start while busy is ignored
    issue(0, BIAS+40, 64'h8765_4321_0FED_CBA9, 0, BIAS, 64'hF000_0000_0000_0001, 0, "R10 start ignored", 1'b1);
    repeat (80) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 pending items: actual %0d expected 0", sb.size());
    end

    // mixed patterns across the exponent range, both modes
    for (int i = 0; i < 40; i++) begin
      logic [15:0] ea;
      logic [63:0] ma, mb;
      ea = BIAS + 16'(i * 2) - 16'd3;
      ma = {1'b1, 31'($urandom), 32'($urandom)};
      mb = {1'b1, 31'($urandom), 32'($urandom)};
      issue(1'($urandom), ea, ma, 1'($urandom), BIAS, mb, 1'(i & 1), "R2_R4_R5 sweep");
    end

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule